// File: doc/BRIEF.md
# Wavefront lane ID initializer

When a workgroup launches one of its wavefronts, every lane of that wavefront needs its place inside the workgroup. This block takes the workgroup size (sx, sy, sz), the wavefront's index inside the workgroup, the workgroup's flat ID and the grid width and height in workgroups. A start pulse captures all of these. The block then produces the three-dimensional workgroup ID, the number of wavefronts the workgroup needs, and one record per lane. Each lane record holds the lane's x/y/z coordinates, its flat ID and whether the lane is active. The active bits also collect into an execution mask.

The lane's linear index is `lane + wave_idx * LANES`. A short setup phase splits the first lane's index, and the workgroup ID, by sizes that are only known at run time. It uses two bit-serial dividers that run in parallel, each used twice. After setup, the lanes stream out one per clock. Each lane's coordinates come from the previous lane's coordinates by an increment with wrap and carry, so no division is needed per lane. Lanes whose index reaches past the end of a partial workgroup are still decomposed, but they are marked inactive.

LANES must be a power of two and at least 2; any other value stops elaboration with an error. All sizes given at start must be nonzero.

Top module: `wave_lane_init`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted start, busy, done and lane_vld are low and exec_mask, wave_count, grp_x, grp_y and grp_z are zero.
- R2: After an accepted start, lane_vld is high for exactly LANES consecutive cycles, with lane_no counting 0 to LANES-1 in order. The lane's linear index is lane_no + wave_idx * LANES.
- R3: lane_act, and bit n of exec_mask for lane n (bit 0 is lane 0), are 1 exactly when the lane's linear index is below sx * sy * sz.
- R4: For every lane, active or not, lane_x = idx mod sx, lane_y = (idx div sx) mod sy and lane_z = idx div (sx * sy).
- R5: lane_flat = lane_z * sx * sy + lane_y * sx + lane_x.
- R6: grp_x = id mod nx, grp_y = (id div nx) mod ny, grp_z = id div (nx * ny), where id is wg_flat_id.
- R7: wave_count equals sx * sy * sz divided by LANES, rounded up.
- R8: done is high for exactly one cycle, the cycle right after the last lane. At that point exec_mask, wave_count and the grp outputs hold the run's results, and they stay unchanged until the next accepted start.
- R9: A start while busy is high, which includes the done cycle, has no effect. The run in flight and its results are unchanged, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when idle |
| wg_sx | input | DIM_W | Workgroup size in x |
| wg_sy | input | DIM_W | Workgroup size in y |
| wg_sz | input | DIM_W | Workgroup size in z |
| wave_idx | input | WAVE_W | Index of the wavefront inside its workgroup |
| wg_flat_id | input | ID_W | Flat ID of the workgroup in the grid |
| grid_nx | input | GRID_W | Grid width in workgroups |
| grid_ny | input | GRID_W | Grid height in workgroups |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last lane |
| exec_mask | output | LANES | Active bit per lane, bit n for lane n |
| wave_count | output | 3*DIM_W | Wavefronts the workgroup needs |
| grp_x | output | GRID_W | Workgroup ID in x |
| grp_y | output | GRID_W | Workgroup ID in y |
| grp_z | output | ID_W | Workgroup ID in z |
| lane_vld | output | 1 | The lane record below is valid |
| lane_no | output | log2(LANES) | Lane number within the wavefront |
| lane_act | output | 1 | The lane is inside the workgroup |
| lane_x | output | DIM_W | Work-item x of the lane |
| lane_y | output | DIM_W | Work-item y of the lane |
| lane_z | output | WAVE_W+log2(LANES) | Work-item z of the lane |
| lane_flat | output | WAVE_W+log2(LANES) | Flat work-item ID of the lane |

## Verification
The bench targets partial workgroups in three ways:
- a wavefront that is only partly inside the workgroup;
- a wavefront that lies entirely past the workgroup's end;
- a workgroup of exactly one item.

A wrong bound in the compare would show up as a mask with one lane too many or too few. The per-lane walk is exercised with x and y sizes of 1, 2, 3, 5, 7 and 16. These make the x wrap, and the carry from y into z, happen at many lane positions. A missing or late carry would give a wrong lane_y or lane_z, and a wrong lane_flat. Workgroup IDs are chosen so that each of the three components is nonzero in some case, and one case has a grid height of 1. A start pulse with different sizes is driven in the middle of a run. A design that accepted it would change the lane stream, or would start a second run after done.

// File: rtl/wli_pkg.sv
package wli_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIV_A = 3'd1,
    ST_DIV_B = 3'd2,
    ST_LANES = 3'd3,
    ST_DONE  = 3'd4
  } wli_state_e;

endpackage

// File: rtl/wli_divider.sv
// Bit-serial restoring divider: one quotient bit per clock, N clocks per divide.
module wli_divider #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] num,
  input  logic [N-1:0] den,
  output logic [N-1:0] quo,
  output logic [N-1:0] rem,
  output logic         fin
);

  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  q_q, q_d, r_q, r_d, d_q, d_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, fin_q, fin_d;

  logic [N:0]    trial;
  logic          fits;
  logic [N-1:0]  diff;

  always_comb begin
    trial = {r_q, q_q[N-1]};
    fits  = trial >= {1'b0, d_q};
    diff  = trial[N-1:0] - d_q;
  end

  always_comb begin
    q_d   = q_q;
    r_d   = r_q;
    d_d   = d_q;
    cnt_d = cnt_q;
    run_d = run_q;
    fin_d = 1'b0;
    if (go) begin
      q_d   = num;
      r_d   = '0;
      d_d   = den;
      cnt_d = CW'(N);
      run_d = 1'b1;
    end else if (run_q) begin
      q_d   = {q_q[N-2:0], fits};
      r_d   = fits ? diff : trial[N-1:0];
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      q_q   <= q_d;
      r_q   <= r_d;
      d_q   <= d_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign quo = q_q;
  assign rem = r_q;
  assign fin = fin_q;

  // The remainder feeds lane_x/lane_y (R4) and grp_x/grp_y (R6).
  p_rem_below_divisor_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (fin && (d_q != '0)) |-> (r_q < d_q));

  // The controller never restarts a divide that is still running.
  p_no_restart_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

endmodule

// File: rtl/wli_lane_walker.sv
// Holds the current lane's x/y/z and steps to the next lane with wrap and carry.
module wli_lane_walker #(
  parameter int DIM_W = 8,
  parameter int IDX_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [DIM_W-1:0]   x0,
  input  logic [DIM_W-1:0]   y0,
  input  logic [IDX_W-1:0]   z0,
  input  logic [DIM_W-1:0]   sx,
  input  logic [DIM_W-1:0]   sy,
  input  logic [2*DIM_W-1:0] sxsy,
  output logic [DIM_W-1:0]   x,
  output logic [DIM_W-1:0]   y,
  output logic [IDX_W-1:0]   z,
  output logic [IDX_W-1:0]   flat
);

  localparam int FW = IDX_W + 2 * DIM_W;

  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [IDX_W-1:0] z_q, z_d;
  logic [DIM_W:0]   x_inc, y_inc;
  logic             x_wrap, y_wrap;
  logic [FW-1:0]    flat_w;

  always_comb begin
    x_inc  = {1'b0, x_q} + 1'b1;
    y_inc  = {1'b0, y_q} + 1'b1;
    x_wrap = x_inc == {1'b0, sx};
    y_wrap = y_inc == {1'b0, sy};
    x_d = x_q;
    y_d = y_q;
    z_d = z_q;
    if (load) begin
      x_d = x0;
      y_d = y0;
      z_d = z0;
    end else if (step) begin
      x_d = x_wrap ? '0 : x_inc[DIM_W-1:0];
      if (x_wrap) begin
        y_d = y_wrap ? '0 : y_inc[DIM_W-1:0];
        if (y_wrap) z_d = z_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (load || step) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  always_comb begin
    flat_w = FW'(z_q) * FW'(sxsy) + FW'(y_q) * FW'(sx) + FW'(x_q);
  end

  assign x    = x_q;
  assign y    = y_q;
  assign z    = z_q;
  assign flat = flat_w[IDX_W-1:0];

  p_x_below_size_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (x_q < sx));

  p_y_below_size_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (y_q < sy));

endmodule

// File: rtl/wave_lane_init.sv
module wave_lane_init
  import wli_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DIM_W  = 8,
  parameter int WAVE_W = 8,
  parameter int ID_W   = 16,
  parameter int GRID_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [DIM_W-1:0]                wg_sx,
  input  logic [DIM_W-1:0]                wg_sy,
  input  logic [DIM_W-1:0]                wg_sz,
  input  logic [WAVE_W-1:0]               wave_idx,
  input  logic [ID_W-1:0]                 wg_flat_id,
  input  logic [GRID_W-1:0]               grid_nx,
  input  logic [GRID_W-1:0]               grid_ny,
  output logic                            busy,
  output logic                            done,
  output logic [LANES-1:0]                exec_mask,
  output logic [3*DIM_W-1:0]              wave_count,
  output logic [GRID_W-1:0]               grp_x,
  output logic [GRID_W-1:0]               grp_y,
  output logic [ID_W-1:0]                 grp_z,
  output logic                            lane_vld,
  output logic [$clog2(LANES)-1:0]        lane_no,
  output logic                            lane_act,
  output logic [DIM_W-1:0]                lane_x,
  output logic [DIM_W-1:0]                lane_y,
  output logic [WAVE_W+$clog2(LANES)-1:0] lane_z,
  output logic [WAVE_W+$clog2(LANES)-1:0] lane_flat
);

  localparam int LOG_L = $clog2(LANES);
  localparam int IDX_W = WAVE_W + LOG_L;
  localparam int DIV_W = (IDX_W > ID_W) ? IDX_W : ID_W;
  localparam int TOT_W = 3 * DIM_W;
  localparam int RND_W = TOT_W + 1;
  localparam int SQ_W  = 2 * DIM_W;
  localparam int CMP_W = (IDX_W > TOT_W) ? IDX_W : TOT_W;
  localparam int NCH   = 2;  // channel 0: lane index, channel 1: workgroup ID

  if ((LANES < 2) || ((LANES & (LANES - 1)) != 0)) begin : g_bad_lanes
    $error("wave_lane_init: LANES has to be a power of two no smaller than 2");
  end

  wli_state_e st_q, st_d;
  logic [LOG_L-1:0]  lane_q, lane_d;
  logic [LANES-1:0]  mask_q, mask_d;

  logic [IDX_W-1:0]  base_q;
  logic [DIM_W-1:0]  sx_q, sy_q, x0_q;
  logic [SQ_W-1:0]   sxsy_q;
  logic [TOT_W-1:0]  total_q, waves_q;
  logic [GRID_W-1:0] ny_q, gx_q, gy_q;
  logic [ID_W-1:0]   gz_q;

  logic [IDX_W-1:0]  base_in;
  logic [TOT_W-1:0]  total_in, waves_in;
  logic [RND_W-1:0]  total_rnd;
  logic [SQ_W-1:0]   sxsy_in;

  logic              cfg_en, setup_a, cap_a, cap_b, walk_step;
  logic [IDX_W-1:0]  lane_idx;

  logic [DIV_W-1:0]  dv_num [NCH];
  logic [DIV_W-1:0]  dv_den [NCH];
  logic [DIV_W-1:0]  dv_quo [NCH];
  logic [DIV_W-1:0]  dv_rem [NCH];
  logic [NCH-1:0]    dv_fin;
  logic              dv_go;

  // Values computed from the raw inputs at the start pulse
  always_comb begin
    base_in   = {wave_idx, {LOG_L{1'b0}}};
    total_in  = TOT_W'(wg_sx) * TOT_W'(wg_sy) * TOT_W'(wg_sz);
    total_rnd = {1'b0, total_in} + RND_W'(LANES - 1);
    waves_in  = TOT_W'(total_rnd >> LOG_L);
    sxsy_in   = SQ_W'(wg_sx) * SQ_W'(wg_sy);
  end

  // Strobes
  always_comb begin
    setup_a   = st_q == ST_IDLE;
    cfg_en    = setup_a && start;
    cap_a     = (st_q == ST_DIV_A) && dv_fin[0];
    cap_b     = (st_q == ST_DIV_B) && dv_fin[0];
    walk_step = st_q == ST_LANES;
    dv_go     = cfg_en || cap_a;
  end

  // Divider operands: first pass splits by x size / grid width, second by y size / grid height
  always_comb begin
    dv_num[0] = setup_a ? DIV_W'(base_in)    : dv_quo[0];
    dv_den[0] = setup_a ? DIV_W'(wg_sx)      : DIV_W'(sy_q);
    dv_num[1] = setup_a ? DIV_W'(wg_flat_id) : dv_quo[1];
    dv_den[1] = setup_a ? DIV_W'(grid_nx)    : DIV_W'(ny_q);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_div
    wli_divider #(.N(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (dv_go),
      .num   (dv_num[c]),
      .den   (dv_den[c]),
      .quo   (dv_quo[c]),
      .rem   (dv_rem[c]),
      .fin   (dv_fin[c])
    );
  end

  wli_lane_walker #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cap_b),
    .step  (walk_step),
    .x0    (x0_q),
    .y0    (dv_rem[0][DIM_W-1:0]),
    .z0    (dv_quo[0][IDX_W-1:0]),
    .sx    (sx_q),
    .sy    (sy_q),
    .sxsy  (sxsy_q),
    .x     (lane_x),
    .y     (lane_y),
    .z     (lane_z),
    .flat  (lane_flat)
  );

  // Next state
  always_comb begin
    st_d     = st_q;
    lane_d   = lane_q;
    mask_d   = mask_q;
    lane_idx = base_q + IDX_W'(lane_q);
    lane_act = CMP_W'(lane_idx) < CMP_W'(total_q);
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_DIV_A;
        mask_d = '0;
      end
      ST_DIV_A: if (dv_fin[0]) st_d = ST_DIV_B;
      ST_DIV_B: if (dv_fin[0]) begin
        st_d   = ST_LANES;
        lane_d = '0;
      end
      ST_LANES: begin
        mask_d = mask_q | (LANES'(lane_act) << lane_q);
        lane_d = lane_q + 1'b1;
        if (lane_q == LOG_L'(LANES - 1)) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lane_q <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      lane_q <= lane_d;
      mask_q <= mask_d;
    end
  end

  // Configuration captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      sx_q    <= '0;
      sy_q    <= '0;
      sxsy_q  <= '0;
      total_q <= '0;
      waves_q <= '0;
      ny_q    <= '0;
    end else if (cfg_en) begin
      base_q  <= base_in;
      sx_q    <= wg_sx;
      sy_q    <= wg_sy;
      sxsy_q  <= sxsy_in;
      total_q <= total_in;
      waves_q <= waves_in;
      ny_q    <= grid_ny;
    end
  end

  // First divide pass results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q <= '0;
      gx_q <= '0;
    end else if (cap_a) begin
      x0_q <= dv_rem[0][DIM_W-1:0];
      gx_q <= dv_rem[1][GRID_W-1:0];
    end
  end

  // Second divide pass results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gy_q <= '0;
      gz_q <= '0;
    end else if (cap_b) begin
      gy_q <= dv_rem[1][GRID_W-1:0];
      gz_q <= dv_quo[1][ID_W-1:0];
    end
  end

  assign busy       = st_q != ST_IDLE;
  assign done       = st_q == ST_DONE;
  assign lane_vld   = st_q == ST_LANES;
  assign lane_no    = lane_q;
  assign exec_mask  = mask_q;
  assign wave_count = waves_q;
  assign grp_x      = gx_q;
  assign grp_y      = gy_q;
  assign grp_z      = gz_q;

  p_lane_order_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && $past(lane_vld)) |-> (lane_no == LOG_L'($past(lane_no) + 1'b1)));

  p_flat_index_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld |-> (lane_flat == base_q + IDX_W'(lane_no)));

  p_done_after_last_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(lane_vld) && ($past(lane_no) == LOG_L'(LANES - 1))));

  p_done_single_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cfg_frozen_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(total_q) && $stable(sx_q)));

endmodule

// File: tb/wave_lane_init_test.sv
module wave_lane_init_test;

  localparam int LANES  = 8;
  localparam int DIM_W  = 8;
  localparam int WAVE_W = 8;
  localparam int ID_W   = 16;
  localparam int GRID_W = 8;
  localparam int LOG_L  = $clog2(LANES);
  localparam int IDX_W  = WAVE_W + LOG_L;
  localparam int NV     = 8;

  // Stimulus: sizes, wave index, workgroup id, grid; expected: mask, wave count, group id
  localparam int T_SX   [NV] = '{4, 3, 5, 2, 7, 1, 16, 3};
  localparam int T_SY   [NV] = '{2, 3, 1, 5, 3, 1, 16, 1};
  localparam int T_SZ   [NV] = '{1, 2, 1, 3, 2, 1, 4, 1};
  localparam int T_WAVE [NV] = '{0, 2, 0, 3, 4, 0, 127, 1};
  localparam int T_ID   [NV] = '{5, 0, 7, 11, 29, 0, 1000, 2};
  localparam int T_NX   [NV] = '{3, 1, 2, 4, 5, 1, 10, 2};
  localparam int T_NY   [NV] = '{2, 1, 2, 3, 2, 1, 10, 1};
  localparam int E_MASK [NV] = '{255, 3, 31, 63, 255, 1, 255, 0};
  localparam int E_WAVE [NV] = '{1, 3, 1, 4, 6, 1, 128, 1};
  localparam int E_GX   [NV] = '{2, 0, 1, 3, 4, 0, 0, 0};
  localparam int E_GY   [NV] = '{1, 0, 1, 2, 1, 0, 0, 0};
  localparam int E_GZ   [NV] = '{0, 0, 1, 0, 2, 0, 10, 1};

  logic                clk, rst_n, start;
  logic [DIM_W-1:0]    wg_sx, wg_sy, wg_sz;
  logic [WAVE_W-1:0]   wave_idx;
  logic [ID_W-1:0]     wg_flat_id;
  logic [GRID_W-1:0]   grid_nx, grid_ny;
  logic                busy, done, lane_vld, lane_act;
  logic [LANES-1:0]    exec_mask;
  logic [3*DIM_W-1:0]  wave_count;
  logic [GRID_W-1:0]   grp_x, grp_y;
  logic [ID_W-1:0]     grp_z;
  logic [LOG_L-1:0]    lane_no;
  logic [DIM_W-1:0]    lane_x, lane_y;
  logic [IDX_W-1:0]    lane_z, lane_flat;

  int n_run = 0;
  int n_bad = 0;

  wave_lane_init #(
    .LANES(LANES), .DIM_W(DIM_W), .WAVE_W(WAVE_W), .ID_W(ID_W), .GRID_W(GRID_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wg_sx(wg_sx), .wg_sy(wg_sy), .wg_sz(wg_sz),
    .wave_idx(wave_idx), .wg_flat_id(wg_flat_id),
    .grid_nx(grid_nx), .grid_ny(grid_ny),
    .busy(busy), .done(done), .exec_mask(exec_mask), .wave_count(wave_count),
    .grp_x(grp_x), .grp_y(grp_y), .grp_z(grp_z),
    .lane_vld(lane_vld), .lane_no(lane_no), .lane_act(lane_act),
    .lane_x(lane_x), .lane_y(lane_y), .lane_z(lane_z), .lane_flat(lane_flat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_checks(input string when);
    chk(busy == 1'b0,     "R1", {when, " busy"},       busy, 0);
    chk(done == 1'b0,     "R1", {when, " done"},       done, 0);
    chk(lane_vld == 1'b0, "R1", {when, " lane_vld"},   lane_vld, 0);
    chk(exec_mask == '0,  "R1", {when, " exec_mask"},  exec_mask, 0);
    chk(wave_count == '0, "R1", {when, " wave_count"}, wave_count, 0);
    chk((grp_x == '0) && (grp_y == '0) && (grp_z == '0), "R1", {when, " group id"},
        grp_x + grp_y + grp_z, 0);
  endtask

  task automatic drive_vec(input int v);
    wg_sx      = DIM_W'(T_SX[v]);
    wg_sy      = DIM_W'(T_SY[v]);
    wg_sz      = DIM_W'(T_SZ[v]);
    wave_idx   = WAVE_W'(T_WAVE[v]);
    wg_flat_id = ID_W'(T_ID[v]);
    grid_nx    = GRID_W'(T_NX[v]);
    grid_ny    = GRID_W'(T_NY[v]);
  endtask

  task automatic run_vec(input int v, input bit poke);
    int seen, guard, idx, tot, ex, ey, ez, ef;
    bit fin, want_done;
    logic [LANES-1:0]   m_hold;
    logic [3*DIM_W-1:0] w_hold;
    tot = T_SX[v] * T_SY[v] * T_SZ[v];
    @(negedge clk);
    drive_vec(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0; guard = 0; fin = 1'b0; want_done = 1'b0;
    while (!fin && guard < 500) begin
      if (want_done) begin
        chk(done == 1'b1, "R8", "done in the cycle after the last lane", done, 1);
        want_done = 1'b0;
      end
      if (lane_vld) begin
        idx = T_WAVE[v] * LANES + seen;
        ex  = idx % T_SX[v];
        ey  = (idx / T_SX[v]) % T_SY[v];
        ez  = idx / (T_SX[v] * T_SY[v]);
        ef  = ez * T_SX[v] * T_SY[v] + ey * T_SX[v] + ex;
        chk(int'(lane_no) == seen, "R2", "lane number in order", lane_no, seen);
        chk(lane_act == (idx < tot), "R3", "lane active bit", lane_act, idx < tot);
        chk(int'(lane_x) == ex, "R4", "lane x", lane_x, ex);
        chk(int'(lane_y) == ey, "R4", "lane y", lane_y, ey);
        chk(int'(lane_z) == ez, "R4", "lane z", lane_z, ez);
        chk(int'(lane_flat) == ef, "R5", "lane flat id", lane_flat, ef);
        seen++;
        if (seen == LANES) want_done = 1'b1;
        if (poke && seen == 4) begin
          // R9: a new start with other sizes while busy
          start      = 1'b1;
          wg_sx      = DIM_W'(13);
          wave_idx   = '0;
          wg_flat_id = '1;
        end else begin
          start = 1'b0;
        end
      end else if (seen > 0 && seen < LANES) begin
        chk(1'b0, "R2", "lanes back to back", 0, 1);
      end
      if (done) begin
        chk(seen == LANES, "R2", "lane count before done", seen, LANES);
        chk(int'(exec_mask) == E_MASK[v], "R3", "exec_mask", exec_mask, E_MASK[v]);
        chk(int'(wave_count) == E_WAVE[v], "R7", "wave_count", wave_count, E_WAVE[v]);
        chk(int'(grp_x) == E_GX[v], "R6", "group x", grp_x, E_GX[v]);
        chk(int'(grp_y) == E_GY[v], "R6", "group y", grp_y, E_GY[v]);
        chk(int'(grp_z) == E_GZ[v], "R6", "group z", grp_z, E_GZ[v]);
        fin = 1'b1;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    if (!fin) chk(1'b0, "R8", "done never arrived", 0, 1);
    start  = 1'b0;
    m_hold = exec_mask;
    w_hold = wave_count;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    chk(busy == 1'b0, "R9", "no second run after ignored start", busy, 0);
    repeat (3) @(negedge clk);
    chk(exec_mask == m_hold, "R8", "exec_mask held after done", exec_mask, m_hold);
    chk(wave_count == w_hold, "R8", "wave_count held after done", wave_count, w_hold);
    chk(int'(grp_z) == E_GZ[v], "R8", "group id held after done", grp_z, E_GZ[v]);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL R8 watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int guard;
    rst_n = 1'b0;
    start = 1'b0;
    drive_vec(0);
    repeat (3) @(negedge clk);
    idle_checks("in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_checks("after reset");

    for (int v = 0; v < NV; v++) begin
      run_vec(v, (v == 3) || (v == 6));
    end

    // Reset in the middle of the lane phase
    @(negedge clk);
    drive_vec(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!lane_vld && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    idle_checks("reset mid-run");
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("release after mid-run reset");
    run_vec(0, 1'b0);
    run_vec(7, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule